// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns a single host request into one timed NAND flash bus cycle. A request goes to one of three targets. A write to the command target or the address target drives the byte with the command latch or the address latch raised. A data-target write drives a plain data byte. A data-target read strobes the read line and returns the captured byte, zero-extended to 32 bits.

Every cycle has three phases: setup, strobe and hold. Each phase has its own programmable length, taken from a packed 32-bit timing word. The read and write directions use separate fields. After a command or address write, the sequencer also holds off for a programmable ready-sample window. Only after that window does it report the device's ready/busy line as trustworthy. Chip enable can be forced low by a configuration input at any time.

The host must wait for `req_ready_o` before issuing the next request. The timing word is sampled once, when a request is accepted.

Top module: `nand_cycle_seq`

## Requirements
- R1: The setup phase lasts (setup field + 1) clocks, from 1 to 16. During setup the latch enables and the write data are driven, and both strobes are high.
- R2: The strobe phase lasts (width field + 1) clocks. A write pulls `nand_we_n_o` low. A read pulls `nand_re_n_o` low. The two strobes are never low together.
- R3: The hold phase lasts (hold field + 1) clocks with both strobes high. Latch enables and write data stay unchanged from the strobe phase through the hold phase.
- R4: Timing word layout. The write fields are ready-wait [31:28], width [27:24], hold [23:20] and setup [19:16]. The read fields are ready-wait [15:12], width [11:8], hold [7:4] and setup [3:0]. The word is captured when the request is accepted; later changes to it do not affect the cycle in progress.
- R5: Target code 0 (command) raises `nand_cle_o` only. Target code 1 (address) raises `nand_ale_o` only. Target codes 2 and 3 (data) raise neither. Both latch enables are never high together.
- R6: After a command or address write whose ready-wait field n is non-zero, the block waits 2*n clocks. During that wait, `req_ready_o` is low and `nand_dev_ready_o` is low. When n = 0, and for data writes and all reads, there is no wait.
- R7: A data read captures `nand_dq_i` on the clock edge where the read strobe returns high. `rsp_valid_o` pulses for one clock in the first hold cycle, and `rsp_rdata_o` carries the byte zero-extended.
- R8: A read aimed at the command or address target runs no bus cycle. It answers on the next clock with `rsp_valid_o` high and data zero.
- R9: `nand_ce_n_o` is low whenever `force_ce_i` is high. It is also low during setup, strobe and hold. It is high otherwise.
- R10: After reset the block is idle: `req_ready_o` is high, both strobes and chip enable are high, and both latch enables are low. `req_ready_o` stays low from the accepting edge until the cycle and any ready wait finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timing_i | input | 32 | Packed phase timing word |
| force_ce_i | input | 1 | Hold chip enable asserted |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Sequencer idle, request accepted this clock |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_target_i | input | 2 | 0 command, 1 address, 2/3 data |
| req_wdata_i | input | 8 | Byte to drive on writes |
| rsp_valid_o | output | 1 | Read response pulse |
| rsp_rdata_o | output | 32 | Read byte, zero-extended |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_n_o | output | 1 | Write strobe, active low |
| nand_re_n_o | output | 1 | Read strobe, active low |
| nand_ce_n_o | output | 1 | Chip enable, active low |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe_o | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rb_i | input | 1 | Device ready/busy line, 1 = ready |
| nand_dev_ready_o | output | 1 | Ready status, forced low during the ready wait |

## Verification
The bench builds the block with its default parameters: an 8-bit device bus, a 32-bit host word and 4-bit timing fields. With these, the field extremes 0 and 15 give phase lengths of 1 and 16 clocks and a ready wait of up to 30 clocks. Timing words are chosen so that every field position takes a distinct value, and so that the read fields differ from the write fields. A wrong slice, a swapped direction or a fixed phase length therefore shows up as a count mismatch. The timing word is changed right after acceptance, which exposes any sequencer that keeps reading the live word.

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq #(
  parameter int DATA_W  = 8,
  parameter int HOST_W  = 32,
  parameter int FIELD_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [8*FIELD_W-1:0] timing_i,
  input  logic                 force_ce_i,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic                 req_write_i,
  input  logic [1:0]           req_target_i,
  input  logic [DATA_W-1:0]    req_wdata_i,
  output logic                 rsp_valid_o,
  output logic [HOST_W-1:0]    rsp_rdata_o,
  output logic                 nand_cle_o,
  output logic                 nand_ale_o,
  output logic                 nand_we_n_o,
  output logic                 nand_re_n_o,
  output logic                 nand_ce_n_o,
  output logic [DATA_W-1:0]    nand_dq_o,
  output logic                 nand_dq_oe_o,
  input  logic [DATA_W-1:0]    nand_dq_i,
  input  logic                 nand_rb_i,
  output logic                 nand_dev_ready_o
);

  localparam int CNT_W  = FIELD_W + 1;
  localparam int HALF_W = 4 * FIELD_W;

  typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD, ST_WAIT} state_t;

  state_t             state;
  logic [CNT_W-1:0]   cnt;
  logic               is_wr, lat_cle, lat_ale;
  logic [DATA_W-1:0]  wbyte;
  logic [FIELD_W-1:0] f_width, f_hold, f_wait;

  logic [HALF_W-1:0]  sel;
  logic               tgt_cle, tgt_ale, active;

  assign sel     = req_write_i ? timing_i[HALF_W +: HALF_W] : timing_i[0 +: HALF_W];
  assign tgt_cle = (req_target_i == 2'd0);
  assign tgt_ale = (req_target_i == 2'd1);
  assign active  = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      is_wr       <= 1'b0;
      lat_cle     <= 1'b0;
      lat_ale     <= 1'b0;
      wbyte       <= '0;
      f_width     <= '0;
      f_hold      <= '0;
      f_wait      <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid_i) begin
          if (!req_write_i && (tgt_cle || tgt_ale)) begin
            rsp_valid_o <= 1'b1;
            rsp_rdata_o <= '0;
          end else begin
            state   <= ST_SETUP;
            cnt     <= CNT_W'(sel[0 +: FIELD_W]);
            f_hold  <= sel[FIELD_W +: FIELD_W];
            f_width <= sel[2*FIELD_W +: FIELD_W];
            f_wait  <= sel[3*FIELD_W +: FIELD_W];
            is_wr   <= req_write_i;
            lat_cle <= tgt_cle;
            lat_ale <= tgt_ale;
            wbyte   <= req_wdata_i;
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            state <= ST_STROBE;
            cnt   <= CNT_W'(f_width);
          end else cnt <= cnt - 1'b1;
        end
        ST_STROBE: begin
          if (cnt == '0) begin
            state <= ST_HOLD;
            cnt   <= CNT_W'(f_hold);
            if (!is_wr) begin
              rsp_valid_o <= 1'b1;
              rsp_rdata_o <= HOST_W'(nand_dq_i);
            end
          end else cnt <= cnt - 1'b1;
        end
        ST_HOLD: begin
          if (cnt == '0) begin
            if (is_wr && (lat_cle || lat_ale) && (f_wait != '0)) begin
              state <= ST_WAIT;
              cnt   <= {f_wait, 1'b0} - CNT_W'(1);
            end else state <= ST_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        ST_WAIT: begin
          if (cnt == '0) state <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o      = (state == ST_IDLE);
  assign nand_cle_o       = active && lat_cle;
  assign nand_ale_o       = active && lat_ale;
  assign nand_we_n_o      = !((state == ST_STROBE) && is_wr);
  assign nand_re_n_o      = !((state == ST_STROBE) && !is_wr);
  assign nand_ce_n_o      = !(force_ce_i || active);
  assign nand_dq_oe_o     = active && is_wr;
  assign nand_dq_o        = nand_dq_oe_o ? wbyte : '0;
  assign nand_dev_ready_o = nand_rb_i && (state != ST_WAIT);

endmodule

// File: rtl/nand_cycle_seq_chk.sv
module nand_cycle_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              force_ce_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              nand_cle_o,
  input logic              nand_ale_o,
  input logic              nand_we_n_o,
  input logic              nand_re_n_o,
  input logic              nand_ce_n_o,
  input logic [DATA_W-1:0] nand_dq_o
);

  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n_o && !nand_re_n_o));

  p_latch_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle_o && nand_ale_o));

  p_data_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n_o) |-> ($stable(nand_dq_o) && $stable(nand_cle_o) && $stable(nand_ale_o)));

  p_capture_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_re_n_o) |-> rsp_valid_o);

  p_force_ce_r9: assert property (@(posedge clk) disable iff (!rst_n)
    force_ce_i |-> !nand_ce_n_o);

  p_busy_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n_o || !nand_re_n_o) |-> !req_ready_o);

endmodule

bind nand_cycle_seq nand_cycle_seq_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/nand_cycle_seq_tb_top.sv
module nand_cycle_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] timing_i = '0;
  logic        force_ce_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_write_i = 1'b0;
  logic [1:0]  req_target_i = '0;
  logic [7:0]  req_wdata_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_rdata_o;
  logic        nand_cle_o, nand_ale_o, nand_we_n_o, nand_re_n_o, nand_ce_n_o;
  logic [7:0]  nand_dq_o;
  logic        nand_dq_oe_o;
  logic [7:0]  nand_dq_i;
  logic        nand_rb_i = 1'b1;
  logic        nand_dev_ready_o;
  logic [7:0]  dev_byte = '0;

  always #2 clk = ~clk;

  assign nand_dq_i = nand_re_n_o ? 8'h00 : dev_byte;

  nand_cycle_seq dut_i (.*);

  typedef struct {
    logic       wr;
    logic       cle;
    logic       ale;
    logic [7:0] wb;
    logic [7:0] rb;
    int         su, wd, ho, wt;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor
  int   m = 0, su = 0, wd = 0, ho = 0, wt = 0;
  logic ob_wr, ob_cle, ob_ale, ob_rsp, ob_devrdy;
  logic [7:0]  ob_dq;
  logic [31:0] ob_rd;

  task automatic finish_item();
    exp_t e;
    if (exp_q.size() == 0) begin
      check("R10 unexpected cycle", 1, 0);
      return;
    end
    e = exp_q[0];
    check("R1 setup clocks", su, e.su);
    check("R2 strobe clocks", wd, e.wd);
    check("R2 strobe select", int'(ob_wr), int'(e.wr));
    check("R3 hold clocks", ho, e.ho);
    check("R5 cle", int'(ob_cle), int'(e.cle));
    check("R5 ale", int'(ob_ale), int'(e.ale));
    check("R6 ready wait clocks", wt, e.wt);
    if (e.wt > 0) check("R6 dev ready low in wait", int'(ob_devrdy), 0);
    if (e.wr) check("R1 write data", int'(ob_dq), int'(e.wb));
    else begin
      check("R7 rsp pulse", int'(ob_rsp), 1);
      check("R7 rsp data", int'(ob_rd), int'({24'h0, e.rb}));
    end
    void'(exp_q.pop_front());
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      case (m)
        0: if (!nand_ce_n_o && !force_ce_i) begin
             m = 1; su = 1;
             check("R10 busy in cycle", int'(req_ready_o), 0);
           end
        1: if (!nand_we_n_o || !nand_re_n_o) begin
             m = 2; wd = 1; ob_wr = !nand_we_n_o;
             ob_cle = nand_cle_o; ob_ale = nand_ale_o; ob_dq = nand_dq_o;
           end else su++;
        2: if (nand_we_n_o && nand_re_n_o) begin
             m = 3; ho = 1; ob_rsp = rsp_valid_o; ob_rd = rsp_rdata_o;
           end else wd++;
        3: if (nand_ce_n_o) begin
             if (req_ready_o) begin wt = 0; m = 0; finish_item(); end
             else begin m = 4; wt = 1; ob_devrdy = nand_dev_ready_o; end
           end else ho++;
        4: if (req_ready_o) begin m = 0; finish_item(); end
           else wt++;
        default: m = 0;
      endcase
    end
  end

  // driver
  task automatic bus_op(input logic wr, input logic [1:0] tgt, input logic [7:0] wb,
                        input logic [7:0] rb, input logic [31:0] tw);
    exp_t e;
    logic [15:0] h;
    h = wr ? tw[31:16] : tw[15:0];
    e.wr = wr; e.cle = (tgt == 2'd0); e.ale = (tgt == 2'd1);
    e.wb = wb; e.rb = rb;
    e.su = int'(h[3:0]) + 1; e.ho = int'(h[7:4]) + 1; e.wd = int'(h[11:8]) + 1;
    e.wt = (wr && tgt < 2'd2) ? 2 * int'(h[15:12]) : 0;
    exp_q.push_back(e);
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    dev_byte = rb; timing_i = tw; req_write_i = wr; req_target_i = tgt;
    req_wdata_i = wb; req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0; timing_i = ~tw; req_wdata_i = ~wb;
    wait (exp_q.size() == 0);
    @(negedge clk);
    check("R10 idle after cycle", int'(req_ready_o), 1);
    check("R6 dev ready after wait", int'(nand_dev_ready_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset ready", int'(req_ready_o), 1);
    check("R10 reset we_n", int'(nand_we_n_o), 1);
    check("R10 reset re_n", int'(nand_re_n_o), 1);
    check("R10 reset ce_n", int'(nand_ce_n_o), 1);
    check("R10 reset latches", int'({nand_cle_o, nand_ale_o}), 0);
    check("R10 reset rsp", int'(rsp_valid_o), 0);

    bus_op(1'b1, 2'd0, 8'h90, 8'h00, 32'h2130_0000); // R5 command, R6 wait 4
    bus_op(1'b1, 2'd1, 8'h5A, 8'h00, 32'h0000_0000); // R1 minimum, R6 no wait
    bus_op(1'b1, 2'd2, 8'hA5, 8'h00, 32'hFFFF_0000); // R2 maximum, data no wait
    bus_op(1'b0, 2'd2, 8'h00, 8'h3C, 32'h0000_F3A2); // R7 read, R4 read fields
    bus_op(1'b0, 2'd3, 8'h00, 8'hC3, 32'hFFFF_0000); // R4 write fields ignored on read
    bus_op(1'b1, 2'd1, 8'h11, 8'h00, 32'hF000_0000); // R6 wait 30
    bus_op(1'b1, 2'd0, 8'hFF, 8'h00, 32'h1C47_5555); // R4 read fields ignored on write

    // R8 read of command target
    @(negedge clk);
    req_write_i = 1'b0; req_target_i = 2'd0; req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    check("R8 rsp pulse", int'(rsp_valid_o), 1);
    check("R8 rsp zero", int'(rsp_rdata_o), 0);
    check("R8 no chip enable", int'(nand_ce_n_o), 1);
    check("R8 still idle", int'(req_ready_o), 1);
    @(negedge clk);
    check("R8 rsp single", int'(rsp_valid_o), 0);

    // R9 force chip enable
    force_ce_i = 1'b1;
    @(negedge clk);
    check("R9 forced ce low", int'(nand_ce_n_o), 0);
    force_ce_i = 1'b0;
    @(negedge clk);
    check("R9 ce released", int'(nand_ce_n_o), 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule